// File: doc/BRIEF.md
# Board-Test Parity Chain Controller

This block gives a chip a board-level connectivity test. In test mode every functional input pin feeds one parity network, and the result drives a single shared output pin. A tester flips one pin at a time and watches the shared pin toggle. A pin that does not make it toggle is open or shorted on the board.

Entry and exit are decided on the rising edge of the active-low system reset, from two mode-select pins. The block enters test mode only when both select pins are low at that edge. Once in test mode, the two select pins are themselves parity members. A power-on reset always returns the block to functional mode. Outside test mode, the shared pin carries the normal-function data bit.

The parity network can be built as a ripple chain or as a balanced tree; a parameter picks one. No free-running clock is used.

Top module: `btc_top`

## Requirements
- R1: Test mode is entered when `mode_sel0_i` and `mode_sel1_i` are both 0 at a 0-to-1 transition of `rst_ni`.
- R2: Test mode is exited when `mode_sel0_i` or `mode_sel1_i` is 1 at a 0-to-1 transition of `rst_ni`.
- R3: While `por_ni` is 0, the block is in functional mode whatever the select pins and `rst_ni` do. After `por_ni` rises, it stays in functional mode until a qualifying `rst_ni` rising edge.
- R4: The mode changes only at a rising edge of `rst_ni` or when `por_ni` is 0. Changing the select pins while `rst_ni` is steady, or a falling edge of `rst_ni`, leaves the mode unchanged.
- R5: In test mode, with every chain member at 0, `shared_o` is 0.
- R6: In test mode, inverting any single bit of `chain_i` inverts `shared_o`. This holds when the bits are raised in descending index order and when they are lowered in ascending index order.
- R7: In test mode, `mode_sel0_i` and `mode_sel1_i` are chain members: inverting either one inverts `shared_o` without leaving test mode.
- R8: In functional mode, `shared_o` equals `func_data_i`, and changing `chain_i` or the select pins has no effect on it.
- R9: In test mode, `func_data_i` has no effect on `shared_o`.
- R10: The ripple variant (`CHAIN_TREE`=0) and the tree variant (`CHAIN_TREE`=1) give the same `shared_o` for every input pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low system reset; its rising edge latches the mode |
| por_ni | input | 1 | Active-low power-on reset; forces functional mode asynchronously |
| mode_sel0_i | input | 1 | Mode-select pin 0; a chain member in test mode |
| mode_sel1_i | input | 1 | Mode-select pin 1; a chain member in test mode |
| chain_i | input | CHAIN_W | Functional input pins that feed the parity chain |
| func_data_i | input | 1 | Normal-function data for the shared pin |
| shared_o | output | 1 | Shared pin: parity result in test mode, functional data otherwise |

## Verification
The assertions check three things at every `rst_ni` rising edge: the mode latched from the select pins at the previous edge, the passthrough of functional data in functional mode, and the low output for an all-zero chain. They also check at every `por_ni` release that the power-on reset left functional mode. Per-pin toggling cannot be seen from reset edges, so the bench shows it. The bench walks each pin up and back down and flips the select pins in test mode. It also shows that select changes between edges and falling reset edges leave the mode alone, and that the ripple and tree builds agree.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_TEST = 1'b1
  } btc_mode_e;

  localparam int unsigned SEL_PINS = 2;
endpackage

// File: rtl/btc_mode_latch.sv
module btc_mode_latch
  import btc_pkg::*;
#(
  parameter int unsigned SEL_W = SEL_PINS
) (
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic [SEL_W-1:0] sel_i,
  output btc_mode_e        mode_o
);
  btc_mode_e mode_q;

  // reset rising edge acts as the latch clock; POR clears asynchronously
  always_ff @(posedge rst_ni or negedge por_ni) begin
    if (!por_ni) mode_q <= MODE_FUNC;
    else         mode_q <= (sel_i == '0) ? MODE_TEST : MODE_FUNC;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/btc_parity_net.sv
module btc_parity_net #(
  parameter int unsigned W    = 18,
  parameter bit          TREE = 1'b1
) (
  input  logic [W-1:0] bits_i,
  output logic         par_o
);
  if (TREE) begin : g_tree
    localparam int unsigned LEVELS = (W > 1) ? $clog2(W) : 1;
    localparam int unsigned PAD    = 1 << LEVELS;
    logic [PAD-1:0] lvl [LEVELS+1];

    assign lvl[0] = PAD'(bits_i);
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      for (genvar i = 0; i < PAD; i++) begin : g_node
        if (i < (PAD >> (l + 1))) begin : g_xor
          assign lvl[l+1][i] = lvl[l][2*i] ^ lvl[l][2*i+1];
        end else begin : g_zero
          assign lvl[l+1][i] = 1'b0;
        end
      end
    end
    assign par_o = lvl[LEVELS][0];
  end else begin : g_ripple
    logic [W-1:0] link;
    assign link[0] = bits_i[0];
    for (genvar i = 1; i < W; i++) begin : g_stage
      assign link[i] = link[i-1] ^ bits_i[i];
    end
    assign par_o = link[W-1];
  end
endmodule

// File: rtl/btc_out_sel.sv
module btc_out_sel
  import btc_pkg::*;
(
  input  btc_mode_e mode_i,
  input  logic      par_i,
  input  logic      func_i,
  output logic      pin_o
);
  always_comb begin
    unique case (mode_i)
      MODE_TEST: pin_o = par_i;
      default:   pin_o = func_i;
    endcase
  end
endmodule

// File: rtl/btc_top.sv
module btc_top
  import btc_pkg::*;
#(
  parameter int unsigned CHAIN_W    = 16,
  parameter bit          CHAIN_TREE = 1'b1
) (
  input  logic               rst_ni,
  input  logic               por_ni,
  input  logic               mode_sel0_i,
  input  logic               mode_sel1_i,
  input  logic [CHAIN_W-1:0] chain_i,
  input  logic               func_data_i,
  output logic               shared_o
);
  localparam int unsigned MEMBERS = CHAIN_W + SEL_PINS;

  btc_mode_e            mode;
  logic [SEL_PINS-1:0]  sel;
  logic [MEMBERS-1:0]   members;
  logic                 parity;
  logic                 test_active;

  assign sel     = {mode_sel1_i, mode_sel0_i};
  assign members = {sel, chain_i};

  btc_mode_latch #(.SEL_W(SEL_PINS)) u_mode (
    .rst_ni (rst_ni),
    .por_ni (por_ni),
    .sel_i  (sel),
    .mode_o (mode)
  );

  btc_parity_net #(.W(MEMBERS), .TREE(CHAIN_TREE)) u_par (
    .bits_i (members),
    .par_o  (parity)
  );

  btc_out_sel u_out (
    .mode_i (mode),
    .par_i  (parity),
    .func_i (func_data_i),
    .pin_o  (shared_o)
  );

  assign test_active = (mode == MODE_TEST);
endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
  parameter int unsigned CHAIN_W = 16
) (
  input logic               rst_ni,
  input logic               por_ni,
  input logic               mode_sel0_i,
  input logic               mode_sel1_i,
  input logic [CHAIN_W-1:0] chain_i,
  input logic               func_data_i,
  input logic               shared_o,
  input logic               test_active
);
  logic por_hit;

  // marks a power-on reset seen since the last reset rising edge
  always_ff @(posedge rst_ni or negedge por_ni) begin
    if (!por_ni) por_hit <= 1'b1;
    else         por_hit <= 1'b0;
  end

  AST_ENTRY_LATCH: assert property (@(posedge rst_ni) disable iff (!por_ni)
    (!mode_sel0_i && !mode_sel1_i) |=> (test_active || por_hit)); // R1

  AST_EXIT_LATCH: assert property (@(posedge rst_ni) disable iff (!por_ni)
    (mode_sel0_i || mode_sel1_i) |=> !test_active); // R2

  AST_POR_FUNC: assert property (@(posedge por_ni) !test_active); // R3

  AST_ZERO_CHAIN_LOW: assert property (@(posedge rst_ni) disable iff (!por_ni)
    (test_active && chain_i == '0 && !mode_sel0_i && !mode_sel1_i) |-> !shared_o); // R5

  AST_FUNC_PASS: assert property (@(posedge rst_ni) disable iff (!por_ni)
    !test_active |-> (shared_o == func_data_i)); // R8
endmodule

bind btc_top btc_checker #(.CHAIN_W(CHAIN_W)) u_chk (
  .rst_ni      (rst_ni),
  .por_ni      (por_ni),
  .mode_sel0_i (mode_sel0_i),
  .mode_sel1_i (mode_sel1_i),
  .chain_i     (chain_i),
  .func_data_i (func_data_i),
  .shared_o    (shared_o),
  .test_active (test_active)
);

// File: tb/tb_btc_top.sv
`timescale 1ns/1ps
module tb_btc_top;
  localparam int unsigned W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_ni = 1'b0, por_ni = 1'b0;
  logic         sel0 = 1'b0, sel1 = 1'b0, func = 1'b0;
  logic [W-1:0] chain = '0;
  logic         out_tree, out_lin;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  btc_top #(.CHAIN_W(W), .CHAIN_TREE(1'b1)) dut (
    .rst_ni(rst_ni), .por_ni(por_ni), .mode_sel0_i(sel0), .mode_sel1_i(sel1),
    .chain_i(chain), .func_data_i(func), .shared_o(out_tree));

  btc_top #(.CHAIN_W(W), .CHAIN_TREE(1'b0)) dut_lin (
    .rst_ni(rst_ni), .por_ni(por_ni), .mode_sel0_i(sel0), .mode_sel1_i(sel1),
    .chain_i(chain), .func_data_i(func), .shared_o(out_lin));

  function automatic logic exp_par();
    return (^chain) ^ sel0 ^ sel1;
  endfunction

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // infers the mode at the pin: functional data is set opposite to parity
  task automatic probe(output bit is_test);
    logic keep;
    keep = func;
    func = ~exp_par();
    settle();
    is_test = (out_tree == exp_par());
    func = keep;
    settle();
  endtask

  task automatic pulse_rst(input logic s0, input logic s1);
    sel0 = s0; sel1 = s1;
    settle();
    rst_ni = 1'b0; settle();
    rst_ni = 1'b1; settle();
  endtask

  task automatic t_reset_state();
    bit t;
    chain = 12'h5A3; func = 1'b1; sel0 = 1'b0; sel1 = 1'b0;
    settle();
    check(out_tree == 1'b1, "R3 por held", out_tree, 1'b1);
    rst_ni = 1'b1; settle();  // rst rising edge while por is 0
    probe(t);
    check(!t, "R3 por dominates rst edge", t, 1'b0);
    por_ni = 1'b1; settle();
    probe(t);
    check(!t, "R3 func after por release", t, 1'b0);
    rst_ni = 1'b0; settle();
  endtask

  task automatic t_enter();
    bit t;
    chain = '0; func = 1'b1;
    pulse_rst(1'b0, 1'b0);
    probe(t);
    check(t, "R1 entry", t, 1'b1);
    check(out_tree == 1'b0, "R5 all low", out_tree, 1'b0);
    func = 1'b0; settle();
    check(out_tree == 1'b0, "R9 func ignored", out_tree, 1'b0);
    func = 1'b1; settle();
    check(out_tree == 1'b0, "R9 func ignored", out_tree, 1'b0);
  endtask

  task automatic t_walk();
    logic prev;
    prev = out_tree;
    for (int i = W - 1; i >= 0; i--) begin
      chain[i] = 1'b1; settle();
      check(out_tree == ~prev, "R6 raise", out_tree, ~prev);
      check(out_lin == out_tree, "R10 raise", out_lin, out_tree);
      prev = out_tree;
    end
    for (int i = 0; i < W; i++) begin
      chain[i] = 1'b0; settle();
      check(out_tree == ~prev, "R6 lower", out_tree, ~prev);
      check(out_lin == out_tree, "R10 lower", out_lin, out_tree);
      prev = out_tree;
    end
    check(out_tree == 1'b0, "R5 back to zero", out_tree, 1'b0);
  endtask

  task automatic t_sel_members();
    logic prev;
    bit t;
    prev = out_tree;
    sel0 = 1'b1; settle();
    check(out_tree == ~prev, "R7 sel0 member", out_tree, ~prev);
    prev = out_tree;
    sel1 = 1'b1; settle();
    check(out_tree == ~prev, "R7 sel1 member", out_tree, ~prev);
    probe(t);
    check(t, "R4 no edge keeps test", t, 1'b1);
    rst_ni = 1'b0; settle();
    probe(t);
    check(t, "R4 falling edge keeps test", t, 1'b1);
    rst_ni = 1'b1; settle();  // rising edge with sels high
    probe(t);
    check(!t, "R2 exit both high", t, 1'b0);
  endtask

  task automatic t_func_ignore();
    bit t;
    func = 1'b0;
    for (int i = 0; i < W; i += 3) begin
      chain[i] = ~chain[i]; settle();
      check(out_tree == 1'b0, "R8 chain ignored", out_tree, 1'b0);
    end
    sel0 = 1'b0; sel1 = 1'b0; settle();
    check(out_tree == 1'b0, "R8 sel ignored", out_tree, 1'b0);
    func = 1'b1; settle();
    check(out_tree == 1'b1, "R8 passthrough", out_tree, 1'b1);
    probe(t);
    check(!t, "R4 sels low without edge", t, 1'b0);
    chain = '0;
  endtask

  task automatic t_single_exit();
    bit t;
    pulse_rst(1'b0, 1'b0);
    probe(t);
    check(t, "R1 re-entry", t, 1'b1);
    pulse_rst(1'b0, 1'b1);
    probe(t);
    check(!t, "R2 exit sel1", t, 1'b0);
    pulse_rst(1'b0, 1'b0);
    pulse_rst(1'b1, 1'b0);
    probe(t);
    check(!t, "R2 exit sel0", t, 1'b0);
  endtask

  task automatic t_por_exit();
    bit t;
    pulse_rst(1'b0, 1'b0);
    probe(t);
    check(t, "R1 entry before por", t, 1'b1);
    por_ni = 1'b0; settle();
    probe(t);
    check(!t, "R3 por clears", t, 1'b0);
    por_ni = 1'b1; settle();
    probe(t);
    check(!t, "R3 stays func", t, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_enter();
    t_walk();
    t_sel_members();
    t_func_ignore();
    t_single_exit();
    t_por_exit();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule